// File: doc/BRIEF.md
# Posted Command Additive Latency Pipeline

This block models the command timing of a DDR2-style memory device. The memory controller may post a READ or WRITE before the row-to-column delay has run out. The device holds each posted command for a programmed additive latency, and then issues it internally. From that delayed issue point the block produces two strobes. A read-data-valid strobe fires at the read latency, which is the additive latency plus the CAS latency. A write-data-expected strobe fires at the write latency, which is one clock less than the read latency. Data storage, bank state and strobe generation on the data lines are not part of this block.

A configuration port sets the latencies, and a load pulse captures them. The port carries a 3-bit additive latency field, read as a plain binary value, a CAS latency field, and the row-to-column delay against which the additive latency is checked. The block accepts a new command every cycle and keeps up to `MAX_AL + MAX_CL` commands in flight in a single shift line. All strobes therefore come out in command order.

A three-state controller governs the block. `ST_IDLE` means nothing is in flight. `ST_BUSY` means at least one command is in the line. `ST_FAULT` means the captured configuration is illegal. The transitions are:
- IDLE→BUSY when a command is accepted.
- IDLE→FAULT when an illegal configuration is loaded.
- BUSY→IDLE when the line drains.
- FAULT→IDLE when a legal configuration is loaded.

Top module: `al_posted_cmd_pipe`

## Requirements
- R1: After reset the block holds AL=0, CL=3 and row-to-column delay 0. After reset `cmd_ready` is 1, `cfg_error` is 0, and all strobes are 0 until a command arrives.
- R2: The additive latency is the binary value of `cfg_al` (0 to 6). A command accepted in cycle T drives `issue_valid` high in cycle T+AL, for one cycle, with `issue_write` equal to its `cmd_write` (1 = WRITE, 0 = READ). With AL=0 this happens in cycle T itself.
- R3: A READ accepted in cycle T raises `rd_data_valid` for exactly one cycle, in cycle T+AL+CL.
- R4: A WRITE accepted in cycle T raises `wr_data_expect` for exactly one cycle, in cycle T+AL+CL-1.
- R5: Commands may be accepted in consecutive cycles, with any mix of READ and WRITE. Each accepted command produces its own strobes at its own latencies, in command order.
- R6: An `cfg_al` code of 7 is reserved. Loading it sets `cfg_error` and holds `cmd_ready` at 0, and no command is accepted.
- R7: Loading an AL greater than `cfg_trcd` sets `cfg_error`. AL equal to `cfg_trcd` is legal.
- R8: Loading a CL outside 2 to 7 sets `cfg_error`.
- R9: A load is captured only when no command is in flight. A command accepted in cycle T keeps the block busy through cycle T+13, and a load in any of those cycles is ignored. A load in cycle T+14 or later is captured. In a cycle where a load is captured, `cmd_ready` is 0.
- R10: Loading a legal configuration while `cfg_error` is set clears the error from the next cycle and restores `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture the configuration fields this cycle |
| cfg_al | input | 3 | Additive latency code |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_trcd | input | 4 | Minimum row-to-column delay in clocks |
| cmd_valid | input | 1 | A READ or WRITE is presented |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_ready | output | 1 | Command is accepted when valid and ready |
| cfg_error | output | 1 | Captured configuration is illegal |
| issue_valid | output | 1 | Internal issue of a posted command |
| issue_write | output | 1 | Type of the command being issued |
| rd_data_valid | output | 1 | Read data due this cycle |
| wr_data_expect | output | 1 | Write data expected this cycle |

## Verification
The bench sweeps every legal AL from 0 to 6 against every CL from 2 to 7, running a lone READ and a lone WRITE under each pair. This shows that each latency tap is selected correctly and that reads and writes land on different taps. Back-to-back bursts of mixed commands, run at a middle configuration and at the deepest one, show that in-flight commands do not disturb each other. The illegal-code, AL-above-delay and out-of-range CL loads tell the three error causes apart. Loads placed one cycle before and at the drain point, and a load that collides with a command, pin down the exact cycle in which a load is captured.

// File: rtl/al_pipe_pkg.sv
package al_pipe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_FAULT = 2'd2
    } al_state_e;

endpackage

// File: rtl/al_cfg_check.sv
module al_cfg_check #(
    parameter int AL_W   = 3,
    parameter int CL_W   = 3,
    parameter int TRCD_W = 4,
    parameter int MAX_AL = 6,
    parameter int MIN_CL = 2,
    parameter int MAX_CL = 7
) (
    input  logic [AL_W-1:0]   al,
    input  logic [CL_W-1:0]   cl,
    input  logic [TRCD_W-1:0] trcd,
    output logic              bad
);

    logic al_reserved;
    logic al_too_long;
    logic cl_out_of_range;

    always_comb begin
        al_reserved     = int'(al) > MAX_AL;
        al_too_long     = int'(al) > int'(trcd);
        cl_out_of_range = (int'(cl) < MIN_CL) || (int'(cl) > MAX_CL);
        bad             = al_reserved || al_too_long || cl_out_of_range;
    end

endmodule

// File: rtl/al_cfg_regs.sv
module al_cfg_regs #(
    parameter int AL_W     = 3,
    parameter int CL_W     = 3,
    parameter int TRCD_W   = 4,
    parameter int RST_AL   = 0,
    parameter int RST_CL   = 3,
    parameter int RST_TRCD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [AL_W-1:0]   al_in,
    input  logic [CL_W-1:0]   cl_in,
    input  logic [TRCD_W-1:0] trcd_in,
    output logic [AL_W-1:0]   al_q,
    output logic [CL_W-1:0]   cl_q,
    output logic [TRCD_W-1:0] trcd_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_q   <= AL_W'(RST_AL);
            cl_q   <= CL_W'(RST_CL);
            trcd_q <= TRCD_W'(RST_TRCD);
        end else if (load_en) begin
            al_q   <= al_in;
            cl_q   <= cl_in;
            trcd_q <= trcd_in;
        end
    end

endmodule

// File: rtl/al_delay_line.sv
module al_delay_line #(
    parameter int DEPTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_wr,
    output logic [DEPTH-1:0] vld_q,
    output logic [DEPTH-1:0] wr_q,
    output logic             upper_occupied
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            wr_q[0]  <= 1'b0;
        end else begin
            vld_q[0] <= push;
            wr_q[0]  <= push & push_wr;
        end
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                wr_q[s]  <= 1'b0;
            end else begin
                vld_q[s] <= vld_q[s-1];
                wr_q[s]  <= wr_q[s-1];
            end
        end
    end

    // Any entry that is still one or more shifts away from leaving the line.
    assign upper_occupied = |vld_q[DEPTH-2:0];

endmodule

// File: rtl/al_tap.sv
module al_tap #(
    parameter int DEPTH = 13,
    parameter int LAT_W = 4
) (
    input  logic [DEPTH-1:0] vld,
    input  logic [DEPTH-1:0] wr,
    input  logic [LAT_W-1:0] lat,
    input  logic             in_vld,
    input  logic             in_wr,
    output logic             out_vld,
    output logic             out_wr
);

    // Latency 0 bypasses the line; latency L takes stage L-1.
    always_comb begin
        out_vld = 1'b0;
        out_wr  = 1'b0;
        if (lat == '0) begin
            out_vld = in_vld;
            out_wr  = in_vld & in_wr;
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(lat) == k + 1) begin
                out_vld = vld[k];
                out_wr  = wr[k];
            end
        end
    end

endmodule

// File: rtl/al_posted_cmd_pipe.sv
module al_posted_cmd_pipe #(
    parameter int AL_W     = 3,
    parameter int CL_W     = 3,
    parameter int TRCD_W   = 4,
    parameter int MAX_AL   = 6,
    parameter int MIN_CL   = 2,
    parameter int MAX_CL   = 7,
    parameter int RST_AL   = 0,
    parameter int RST_CL   = 3,
    parameter int RST_TRCD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [AL_W-1:0]   cfg_al,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic [TRCD_W-1:0] cfg_trcd,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    output logic              cmd_ready,
    output logic              cfg_error,
    output logic              issue_valid,
    output logic              issue_write,
    output logic              rd_data_valid,
    output logic              wr_data_expect
);
    import al_pipe_pkg::*;

    localparam int DEPTH = MAX_AL + MAX_CL;
    localparam int LAT_W = $clog2((2 ** AL_W) + (2 ** CL_W));

    al_state_e state_q, state_d;

    logic              accept;
    logic              load_en;
    logic              cfg_bad_in;
    logic [AL_W-1:0]   al_q;
    logic [CL_W-1:0]   cl_q;
    logic [TRCD_W-1:0] trcd_q;
    logic [DEPTH-1:0]  line_vld;
    logic [DEPTH-1:0]  line_wr;
    logic              line_upper;
    logic [LAT_W-1:0]  lat_issue;
    logic [LAT_W-1:0]  lat_read;
    logic [LAT_W-1:0]  lat_write;
    logic              rd_tap_vld, rd_tap_wr;
    logic              wr_tap_vld, wr_tap_wr;

    assign accept  = cmd_valid & cmd_ready;
    assign load_en = cfg_load & (state_q != ST_BUSY);

    al_cfg_check #(
        .AL_W(AL_W), .CL_W(CL_W), .TRCD_W(TRCD_W),
        .MAX_AL(MAX_AL), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL)
    ) u_check (
        .al   (cfg_al),
        .cl   (cfg_cl),
        .trcd (cfg_trcd),
        .bad  (cfg_bad_in)
    );

    al_cfg_regs #(
        .AL_W(AL_W), .CL_W(CL_W), .TRCD_W(TRCD_W),
        .RST_AL(RST_AL), .RST_CL(RST_CL), .RST_TRCD(RST_TRCD)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .al_in   (cfg_al),
        .cl_in   (cfg_cl),
        .trcd_in (cfg_trcd),
        .al_q    (al_q),
        .cl_q    (cl_q),
        .trcd_q  (trcd_q)
    );

    al_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk            (clk),
        .rst_n          (rst_n),
        .push           (accept),
        .push_wr        (cmd_write),
        .vld_q          (line_vld),
        .wr_q           (line_wr),
        .upper_occupied (line_upper)
    );

    always_comb begin
        lat_issue = LAT_W'(al_q);
        lat_read  = LAT_W'(al_q) + LAT_W'(cl_q);
        lat_write = lat_read - LAT_W'(1);
    end

    al_tap #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_tap_issue (
        .vld     (line_vld),
        .wr      (line_wr),
        .lat     (lat_issue),
        .in_vld  (accept),
        .in_wr   (cmd_write),
        .out_vld (issue_valid),
        .out_wr  (issue_write)
    );

    al_tap #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_tap_read (
        .vld     (line_vld),
        .wr      (line_wr),
        .lat     (lat_read),
        .in_vld  (1'b0),
        .in_wr   (1'b0),
        .out_vld (rd_tap_vld),
        .out_wr  (rd_tap_wr)
    );

    al_tap #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_tap_write (
        .vld     (line_vld),
        .wr      (line_wr),
        .lat     (lat_write),
        .in_vld  (1'b0),
        .in_wr   (1'b0),
        .out_vld (wr_tap_vld),
        .out_wr  (wr_tap_wr)
    );

    assign rd_data_valid  = rd_tap_vld & ~rd_tap_wr;
    assign wr_data_expect = wr_tap_vld & wr_tap_wr;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_load) begin
                    state_d = cfg_bad_in ? ST_FAULT : ST_IDLE;
                end else if (accept) begin
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (!line_upper && !accept) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (cfg_load && !cfg_bad_in) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        cmd_ready = 1'b0;
        cfg_error = 1'b0;
        unique case (state_q)
            ST_IDLE:  cmd_ready = ~cfg_load;
            ST_BUSY:  cmd_ready = 1'b1;
            ST_FAULT: cfg_error = 1'b1;
            default: begin
                cmd_ready = 1'b0;
                cfg_error = 1'b0;
            end
        endcase
    end

    assert_zero_al_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && al_q == '0) |-> (issue_valid && issue_write == cmd_write));

    assert_min_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_write && al_q == '0 && int'(cl_q) == 2) |=> ##1 rd_data_valid);

    assert_min_write_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_write && al_q == '0 && int'(cl_q) == 2) |=> wr_data_expect);

    assert_strobes_need_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_valid || wr_data_expect) |-> (state_q == ST_BUSY));

    assert_reserved_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(al_q) > MAX_AL) |-> (!cmd_ready && cfg_error));

    assert_al_within_trcd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(al_q) > int'(trcd_q)) |-> cfg_error);

    assert_cl_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cl_q) < MIN_CL || int'(cl_q) > MAX_CL) |-> cfg_error);

    assert_cfg_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> $stable({al_q, cl_q, trcd_q}));

endmodule

// File: tb/al_posted_cmd_pipe_test.sv
module al_posted_cmd_pipe_test;

    localparam int DEPTH = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_al = '0;
    logic [2:0] cfg_cl = '0;
    logic [3:0] cfg_trcd = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic       cmd_ready, cfg_error, issue_valid, issue_write;
    logic       rd_data_valid, wr_data_expect;

    always #2 clk = ~clk;

    al_posted_cmd_pipe uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_load       (cfg_load),
        .cfg_al         (cfg_al),
        .cfg_cl         (cfg_cl),
        .cfg_trcd       (cfg_trcd),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_ready      (cmd_ready),
        .cfg_error      (cfg_error),
        .issue_valid    (issue_valid),
        .issue_write    (issue_write),
        .rd_data_valid  (rd_data_valid),
        .wr_data_expect (wr_data_expect)
    );

    int    n_vec  = 0;
    int    n_bad  = 0;
    int    cyc_n  = 0;
    int    last_acc = -1;
    int    m_al = 0, m_cl = 3, m_trcd = 0;
    bit    m_fault = 1'b0;
    string ph = "R1";
    bit    exp_iss [64];
    bit    exp_iw  [64];
    bit    exp_rd  [64];
    bit    exp_wr  [64];

    task automatic chk(input string tag, input string name, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", tag, name, cyc_n, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input bit w, input bit ld, input int al, input int cl, input int trcd);
        bit idle, e_ready, acc;
        int i;
        @(negedge clk);
        cmd_valid = v;
        cmd_write = w;
        cfg_load  = ld;
        cfg_al    = al[2:0];
        cfg_cl    = cl[2:0];
        cfg_trcd  = trcd[3:0];
        #1;
        idle    = (last_acc < 0) || (cyc_n > last_acc + DEPTH);
        e_ready = !m_fault && !(idle && ld);
        acc     = v && e_ready;
        if (acc) begin
            exp_iss[(cyc_n + m_al) % 64] = 1'b1;
            exp_iw[(cyc_n + m_al) % 64]  = w;
            if (!w) exp_rd[(cyc_n + m_al + m_cl) % 64] = 1'b1;
            else    exp_wr[(cyc_n + m_al + m_cl - 1) % 64] = 1'b1;
            last_acc = cyc_n;
        end
        i = cyc_n % 64;
        chk(ph, "cmd_ready", cmd_ready, e_ready);
        chk(ph, "cfg_error", cfg_error, m_fault);
        chk("R2", "issue_valid", issue_valid, exp_iss[i]);
        if (exp_iss[i]) chk("R2", "issue_write", issue_write, exp_iw[i]);
        chk("R3", "rd_data_valid", rd_data_valid, exp_rd[i]);
        chk("R4", "wr_data_expect", wr_data_expect, exp_wr[i]);
        exp_iss[i] = 1'b0;
        exp_iw[i]  = 1'b0;
        exp_rd[i]  = 1'b0;
        exp_wr[i]  = 1'b0;
        if (ld && idle) begin
            m_al    = al;
            m_cl    = cl;
            m_trcd  = trcd;
            m_fault = (al > 6) || (al > trcd) || (cl < 2) || (cl > 7);
        end
        cyc_n++;
    endtask

    task automatic idle_n(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 0, 0, 0);
    endtask

    task automatic load(input int al, input int cl, input int trcd);
        cyc(1'b0, 1'b0, 1'b1, al, cl, trcd);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc_n);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) begin
            exp_iss[k] = 1'b0; exp_iw[k] = 1'b0; exp_rd[k] = 1'b0; exp_wr[k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and reset latencies (AL=0, CL=3).
        ph = "R1";
        idle_n(2);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);

        // R2 R3 R4: full sweep of legal AL against legal CL, AL equal to tRCD.
        ph = "R2";
        for (int a = 0; a <= 6; a++) begin
            for (int c = 2; c <= 7; c++) begin
                load(a, c, a);
                cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
                idle_n(2);
                cyc(1'b1, 1'b1, 1'b0, 0, 0, 0);
                idle_n(DEPTH + 2);
            end
        end

        // R5: back-to-back mixed commands, mid and deepest configurations.
        ph = "R5";
        load(3, 4, 5);
        for (int k = 0; k < 12; k++) cyc(1'b1, (k % 3) == 1, 1'b0, 0, 0, 0);
        cyc(1'b1, 1'b1, 1'b0, 0, 0, 0);
        idle_n(1);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);
        load(6, 7, 6);
        for (int k = 0; k < 8; k++) cyc(1'b1, k[0], 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);

        // R6: reserved AL code, then R10 recovery.
        ph = "R6";
        load(7, 3, 9);
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);
        ph = "R10";
        load(2, 3, 2);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);

        // R7: AL above tRCD faults, AL equal to tRCD is legal.
        ph = "R7";
        load(5, 3, 4);
        cyc(1'b1, 1'b1, 1'b0, 0, 0, 0);
        load(4, 3, 4);
        cyc(1'b1, 1'b1, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);

        // R8: CL out of range.
        ph = "R8";
        load(0, 1, 0);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        load(0, 0, 0);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        load(1, 7, 1);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);

        // R9: loads while busy are ignored up to the drain point.
        ph = "R9";
        load(1, 2, 1);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        cyc(1'b1, 1'b1, 1'b1, 5, 6, 5);
        idle_n(DEPTH - 1);
        cyc(1'b0, 1'b0, 1'b1, 6, 7, 6);
        cyc(1'b0, 1'b0, 1'b1, 5, 6, 5);
        cyc(1'b1, 1'b0, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);
        cyc(1'b1, 1'b0, 1'b1, 0, 2, 0);
        cyc(1'b1, 1'b1, 1'b0, 0, 0, 0);
        idle_n(DEPTH + 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule